// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Controller

This block sits on the device side of a message-signalled interrupt scheme with `NUM_VEC` vectors. For every vector it keeps a table entry: a 64-bit message address, a 32-bit message data word and a mask bit. It also keeps one pending bit per vector, a per-vector use count, and two function-level control bits, enable and mask-all. Device logic raises per-vector request pulses. Software reaches the table and the pending bits through a 32-bit word port and writes the control bits through a separate control strobe. Each delivered interrupt leaves on a valid/ready message port that carries address, data and vector number.

A vector only delivers when its use count is non-zero. It is blocked while its effective mask is set, which happens when the function is disabled, when mask-all is set, or when its own mask bit is set. A request that arrives while the vector is blocked is held as pending. The controller replays it once the vector becomes unmasked. Pending vectors that become deliverable together go out one at a time, lowest vector number first, and only one message is in flight at a time.

Top module: `msgvec_ctrl`

## Requirements
- R1: After reset every address and data word of the table reads 0, every vector-control word reads 1 (mask set), every pending bit reads 0, `ctl_word` bits 15 (enable) and 14 (mask-all) read 0, and `ctl_word[10:0]` reads `NUM_VEC-1`.
- R2: With `reg_space`=0, `reg_addr` is a 32-bit word index with the vector in bits `[AW-1:2]` and the word in bits `[1:0]`: 0 is address low, 1 is address high, 2 is data, 3 is vector control. In vector control only bit 0 (mask) is stored, and the other bits read 0. Writes take effect at the clock edge, and reads are combinational.
- R3: A vector's effective mask is its own mask bit, OR enable clear, OR mask-all set. A vector whose effective mask is set never has a message issued.
- R4: A request for a vector whose use count is 0 is dropped. It produces no message and sets no pending bit.
- R5: A request for a vector that is in use and masked sets its pending bit and produces no message. With `reg_space`=1, pending word k holds vectors 32k to 32k+31, and vector v sits at bit v mod 32.
- R6: A request for a vector that is in use and unmasked, arriving while `msg_valid` is low, raises `msg_valid` at the same edge that samples it. The port then carries `msg_addr`={address high, address low}, `msg_data`=data and `msg_vec`=v, and no pending bit is left set.
- R7: When pending vectors become unmasked, through their own mask bit or through the function mask, each pending bit is cleared and its message is sent. Several such vectors go out in ascending vector order.
- R8: Writes with `reg_space`=1 have no effect on the pending bits.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr`, `msg_data` and `msg_vec` hold. A new message is launched only while `msg_valid` is low.
- R10: A control write (`ctl_wr`) with `ctl_wdata[0]`=1 (enable) pulses `intx_clr` high for the following cycle. A control write with enable 0 leaves it low. `ctl_wdata[1]` is mask-all.
- R11: `use_inc` and `use_dec` adjust the use count of `use_vec`. A decrement from 1 to 0 clears that vector's pending bit. A decrement at 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_space | input | 1 | 0 selects the table, 1 selects the pending bits |
| reg_addr | input | AW | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_space`/`reg_addr` |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | {mask-all, enable} |
| ctl_word | output | 16 | {enable, mask-all, 3'b0, NUM_VEC-1} |
| irq_req | input | NUM_VEC | Per-vector request pulses |
| use_inc | input | 1 | Increment the use count of `use_vec` |
| use_dec | input | 1 | Decrement the use count of `use_vec` |
| use_vec | input | VW | Vector for use-count operations |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | VW | Vector number of the message |
| intx_clr | output | 1 | Legacy line deassert pulse |

## Verification
The bench fires requests at vectors that are not in use. A controller that skips the use-count check would emit messages or set pending bits there. It clears mask-all while three vectors are pending and `msg_ready` is held low. A wrong design would emit the vectors out of order, drop one of them, or change the message while it is waiting to be accepted. It also decrements a use count once past zero and then increments it once. A counter that wraps would leave the vector out of use and lose the next pending bit. Finally, it writes ones into the pending space and clears the enable bit while a vector is unmasked, which catches a pending array that can be written and a function mask that ignores the enable bit.

// File: rtl/msgvec_pkg.sv
package msgvec_pkg;
  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } word_sel_e;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_MA_BIT  = 1;
  localparam int ST_EN_BIT   = 15;
  localparam int ST_MA_BIT   = 14;
  localparam int ST_SIZE_W   = 11;

  // word of the pending space that holds a given vector
  function automatic int unsigned pend_word(input int unsigned vec);
    return vec / 32;
  endfunction

  function automatic int unsigned pend_bit(input int unsigned vec);
    return vec % 32;
  endfunction
endpackage

// File: rtl/msgvec_table.sv
module msgvec_table
  import msgvec_pkg::*;
#(
  parameter int NV = 8,
  parameter int VW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [VW-1:0] wr_vec,
  input  logic [1:0]    wr_word,
  input  logic [31:0]   wr_data,
  input  logic [VW-1:0] rd_vec,
  input  logic [1:0]    rd_word,
  output logic [31:0]   rd_data,
  input  logic [VW-1:0] pick_vec,
  output logic [63:0]   pick_addr,
  output logic [31:0]   pick_data,
  output logic [NV-1:0] vmask
);
  logic [31:0] addr_lo [NV];
  logic [31:0] addr_hi [NV];
  logic [31:0] data_w  [NV];
  logic [NV-1:0] vmask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NV; i++) begin
        addr_lo[i] <= '0;
        addr_hi[i] <= '0;
        data_w[i]  <= '0;
      end
      vmask_q <= '1;
    end else if (wr_en && (int'(wr_vec) < NV)) begin
      unique case (word_sel_e'(wr_word))
        W_ADDR_LO: addr_lo[wr_vec] <= wr_data;
        W_ADDR_HI: addr_hi[wr_vec] <= wr_data;
        W_DATA:    data_w[wr_vec]  <= wr_data;
        W_CTRL:    vmask_q[wr_vec] <= wr_data[0];
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_vec) < NV) begin
      unique case (word_sel_e'(rd_word))
        W_ADDR_LO: rd_data = addr_lo[rd_vec];
        W_ADDR_HI: rd_data = addr_hi[rd_vec];
        W_DATA:    rd_data = data_w[rd_vec];
        W_CTRL:    rd_data = {31'd0, vmask_q[rd_vec]};
      endcase
    end
  end

  assign pick_addr = {addr_hi[pick_vec], addr_lo[pick_vec]};
  assign pick_data = data_w[pick_vec];
  assign vmask     = vmask_q;
endmodule

// File: rtl/msgvec_usecnt.sv
module msgvec_usecnt #(
  parameter int NV = 8,
  parameter int VW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic [VW-1:0] vec,
  output logic [NV-1:0] in_use,
  output logic [NV-1:0] drop
);
  for (genvar g = 0; g < NV; g++) begin : g_cnt
    logic [CW-1:0] cnt;
    logic          hit;
    assign hit = (vec == VW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
      end else if (hit && inc && !dec && (cnt != '1)) begin
        cnt <= cnt + 1'b1;
      end else if (hit && dec && !inc && (cnt != '0)) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign in_use[g] = (cnt != '0);
    assign drop[g]   = hit && dec && !inc && (cnt == CW'(1));
  end
endmodule

// File: rtl/msgvec_arb.sv
module msgvec_arb #(
  parameter int NV = 8,
  parameter int VW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NV-1:0] req,
  input  logic [NV-1:0] in_use,
  input  logic [NV-1:0] emask,
  input  logic [NV-1:0] drop,
  input  logic          msg_ready,
  input  logic [63:0]   pick_addr,
  input  logic [31:0]   pick_data,
  output logic          launch,
  output logic [VW-1:0] pick_vec,
  output logic [NV-1:0] pend,
  output logic          msg_valid,
  output logic [63:0]   msg_addr,
  output logic [31:0]   msg_data,
  output logic [VW-1:0] msg_vec
);
  // lowest-numbered set bit
  function automatic logic [VW-1:0] first_set(input logic [NV-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (v[i]) r = VW'(i);
    end
    return r;
  endfunction

  logic [NV-1:0] pend_q, merged, cand, pend_d;

  assign merged   = pend_q | (req & in_use);
  assign cand     = merged & ~emask;
  assign launch   = !msg_valid && (cand != '0);
  assign pick_vec = first_set(cand);

  always_comb begin
    pend_d = merged;
    if (launch) pend_d[pick_vec] = 1'b0;
    pend_d = pend_d & ~drop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_vec   <= '0;
    end else begin
      pend_q <= pend_d;
      if (launch) begin
        msg_valid <= 1'b1;
        msg_addr  <= pick_addr;
        msg_data  <= pick_data;
        msg_vec   <= pick_vec;
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/msgvec_ctrl.sv
module msgvec_ctrl
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int AW = VW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_space,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               ctl_wr,
  input  logic [1:0]         ctl_wdata,
  output logic [15:0]        ctl_word,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               use_inc,
  input  logic               use_dec,
  input  logic [VW-1:0]      use_vec,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [VW-1:0]      msg_vec,
  output logic               intx_clr
);
  localparam int NV = NUM_VEC;
  localparam int PW = (NV + 31) / 32;

  logic          enable_q, maskall_q, intx_q, fmask;
  logic [NV-1:0] vmask, emask, in_use, drop, pend;
  logic [31:0]   tbl_rdata, pick_data;
  logic [63:0]   pick_addr;
  logic [VW-1:0] pick_vec;
  logic          launch;
  logic [PW*32-1:0] pend_pad;
  logic [31:0]   pend_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q  <= 1'b0;
      maskall_q <= 1'b0;
      intx_q    <= 1'b0;
    end else begin
      intx_q <= ctl_wr && ctl_wdata[CTL_EN_BIT];
      if (ctl_wr) begin
        enable_q  <= ctl_wdata[CTL_EN_BIT];
        maskall_q <= ctl_wdata[CTL_MA_BIT];
      end
    end
  end

  assign fmask = !enable_q || maskall_q;
  assign emask = vmask | {NV{fmask}};

  msgvec_table #(.NV(NV), .VW(VW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr && !reg_space), .wr_vec(reg_addr[AW-1:2]),
    .wr_word(reg_addr[1:0]), .wr_data(reg_wdata),
    .rd_vec(reg_addr[AW-1:2]), .rd_word(reg_addr[1:0]), .rd_data(tbl_rdata),
    .pick_vec(pick_vec), .pick_addr(pick_addr), .pick_data(pick_data),
    .vmask(vmask)
  );

  msgvec_usecnt #(.NV(NV), .VW(VW), .CW(CNT_W)) u_use (
    .clk(clk), .rst_n(rst_n), .inc(use_inc), .dec(use_dec), .vec(use_vec),
    .in_use(in_use), .drop(drop)
  );

  msgvec_arb #(.NV(NV), .VW(VW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .in_use(in_use), .emask(emask),
    .drop(drop), .msg_ready(msg_ready), .pick_addr(pick_addr),
    .pick_data(pick_data), .launch(launch), .pick_vec(pick_vec), .pend(pend),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .msg_vec(msg_vec)
  );

  always_comb begin
    pend_pad = '0;
    pend_pad[NV-1:0] = pend;
    pend_rdata = '0;
    for (int k = 0; k < PW; k++) begin
      if (int'(reg_addr) == k) pend_rdata = pend_pad[k*32 +: 32];
    end
  end

  assign reg_rdata = reg_space ? pend_rdata : tbl_rdata;
  assign ctl_word  = {enable_q, maskall_q, 3'b000, ST_SIZE_W'(NV - 1)};
  assign intx_clr  = intx_q;
endmodule

// File: rtl/msgvec_checker.sv
module msgvec_checker #(
  parameter int NV = 8,
  parameter int VW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [63:0]   msg_addr,
  input logic [31:0]   msg_data,
  input logic [VW-1:0] msg_vec,
  input logic          launch,
  input logic [VW-1:0] pick_vec,
  input logic [NV-1:0] emask,
  input logic [NV-1:0] pend,
  input logic          ctl_wr,
  input logic          ctl_en,
  input logic          intx_clr
);
  // R9: a waiting message holds its content
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) &&
    $stable(msg_data) && $stable(msg_vec));

  // R9: only one message in flight
  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !msg_valid);

  // R3: a launched vector is never effectively masked
  p_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !emask[pick_vec]);

  // R7: an unmasked pending vector is issued once the port is free
  p_replay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid && ((pend & ~emask) != '0) |=> msg_valid);

  // R10: enabling control write pulses the legacy deassert
  p_intx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_en |=> intx_clr);

  p_intx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && ctl_en) |=> !intx_clr);
endmodule

bind msgvec_ctrl msgvec_checker #(.NV(NV), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec),
  .launch(launch), .pick_vec(pick_vec), .emask(emask), .pend(pend),
  .ctl_wr(ctl_wr), .ctl_en(ctl_wdata[0]), .intx_clr(intx_clr)
);

// File: tb/msgvec_ctrl_test.sv
module msgvec_ctrl_test;
  localparam int NV = 8;
  localparam int VW = 3;
  localparam int AW = VW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_space = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          ctl_wr = 1'b0;
  logic [1:0]    ctl_wdata = '0;
  logic [15:0]   ctl_word;
  logic [NV-1:0] irq_req = '0;
  logic          use_inc = 1'b0, use_dec = 1'b0;
  logic [VW-1:0] use_vec = '0;
  logic          msg_valid, msg_ready = 1'b1;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;
  logic [VW-1:0] msg_vec;
  logic          intx_clr;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  msgvec_ctrl #(.NUM_VEC(NV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_space(reg_space),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_word(ctl_word),
    .irq_req(irq_req), .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_vec(msg_vec), .intx_clr(intx_clr)
  );

  always #2 clk = ~clk;

  // accepted-message log
  int          lg_n = 0;
  logic [VW-1:0] lg_vec [32];
  logic [63:0] lg_addr [32];
  logic [31:0] lg_data [32];
  always @(negedge clk) begin
    #1;
    if (rst_n && msg_valid && msg_ready && lg_n < 32) begin
      lg_vec[lg_n]  = msg_vec;
      lg_addr[lg_n] = msg_addr;
      lg_data[lg_n] = msg_data;
      lg_n++;
    end
  end

  function automatic logic [63:0] exp_addr(int v);
    return {32'(v), 32'hFEE0_0000 + 32'(v * 16)};
  endfunction

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(bit space, int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_space = space; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(bit space, int a, output logic [31:0] d);
    @(negedge clk);
    reg_space = space; reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic ctl_write(bit ma, bit en, string rq);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = {ma, en};
    @(negedge clk);
    ctl_wr = 1'b0;
    #1 chk(rq, "intx_clr after control write", 64'(intx_clr), 64'(en));
  endtask

  task automatic pulse_irq(logic [NV-1:0] m);
    @(negedge clk);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic use_op(bit inc, int v);
    @(negedge clk);
    use_inc = inc; use_dec = !inc; use_vec = VW'(v);
    @(negedge clk);
    use_inc = 1'b0; use_dec = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    reg_read(0, 0 * 4 + 3, d); chk("R1", "v0 ctrl", 64'(d), 64'd1);
    reg_read(0, 7 * 4 + 3, d); chk("R1", "v7 ctrl", 64'(d), 64'd1);
    reg_read(0, 3 * 4 + 0, d); chk("R1", "v3 addr lo", 64'(d), 64'd0);
    reg_read(0, 5 * 4 + 2, d); chk("R1", "v5 data", 64'(d), 64'd0);
    reg_read(1, 0, d);         chk("R1", "pending", 64'(d), 64'd0);
    chk("R1", "ctl_word", 64'(ctl_word), 64'h0007);
    chk("R1", "msg_valid", 64'(msg_valid), 64'd0);
  endtask

  task automatic t_table;
    logic [31:0] d;
    for (int v = 0; v < NV; v++) begin
      reg_write(0, v * 4 + 0, exp_addr(v)[31:0]);
      reg_write(0, v * 4 + 1, exp_addr(v)[63:32]);
      reg_write(0, v * 4 + 2, 32'h100 + 32'(v));
    end
    for (int v = 0; v < NV; v++) begin
      reg_read(0, v * 4 + 0, d); chk("R2", "addr lo", 64'(d), 64'(exp_addr(v)[31:0]));
      reg_read(0, v * 4 + 1, d); chk("R2", "addr hi", 64'(d), 64'(v));
      reg_read(0, v * 4 + 2, d); chk("R2", "data", 64'(d), 64'h100 + 64'(v));
    end
    reg_write(0, 0 * 4 + 3, 32'hFFFF_FFFE);
    reg_read(0, 0 * 4 + 3, d); chk("R2", "v0 ctrl cleared", 64'(d), 64'd0);
    reg_write(0, 0 * 4 + 3, 32'hFFFF_FFFF);
    reg_read(0, 0 * 4 + 3, d); chk("R2", "v0 ctrl only bit0", 64'(d), 64'd1);
    reg_read(0, 6 * 4 + 3, d); chk("R2", "v6 ctrl untouched", 64'(d), 64'd1);
  endtask

  task automatic t_drop_unused;
    logic [31:0] d;
    int n0;
    ctl_write(1'b0, 1'b1, "R10");
    chk("R1", "ctl_word enabled", 64'(ctl_word), 64'h8007);
    reg_write(0, 2 * 4 + 3, 32'h0);
    n0 = lg_n;
    pulse_irq(8'h04);
    tick(4);
    chk("R4", "no message for unused vector", 64'(lg_n), 64'(n0));
    reg_read(1, 0, d); chk("R4", "no pending for unused vector", 64'(d), 64'd0);
  endtask

  task automatic t_immediate;
    int n0;
    use_op(1'b1, 2);
    n0 = lg_n;
    pulse_irq(8'h04);
    #1 chk("R6", "msg_valid at sampling edge", 64'(msg_valid), 64'd1);
    chk("R6", "msg_vec", 64'(msg_vec), 64'd2);
    tick(3);
    chk("R6", "one message", 64'(lg_n), 64'(n0 + 1));
    chk("R6", "addr", lg_addr[n0], exp_addr(2));
    chk("R6", "data", 64'(lg_data[n0]), 64'h102);
  endtask

  task automatic t_masked_replay;
    logic [31:0] d;
    int n0;
    use_op(1'b1, 5);
    n0 = lg_n;
    pulse_irq(8'h20);
    tick(3);
    chk("R5", "no message while masked", 64'(lg_n), 64'(n0));
    reg_read(1, 0, d); chk("R5", "pending bit 5", 64'(d), 64'h20);
    reg_write(1, 0, 32'hFFFF_FFFF);
    reg_write(1, 0, 32'h0);
    reg_read(1, 0, d); chk("R8", "pending unchanged by writes", 64'(d), 64'h20);
    reg_write(0, 5 * 4 + 3, 32'h0);
    tick(4);
    chk("R7", "replayed message", 64'(lg_n), 64'(n0 + 1));
    chk("R7", "replayed vec", 64'(lg_vec[n0]), 64'd5);
    chk("R7", "replayed data", 64'(lg_data[n0]), 64'h105);
    reg_read(1, 0, d); chk("R7", "pending cleared", 64'(d), 64'd0);
  endtask

  task automatic t_function_mask;
    logic [31:0] d;
    int n0;
    ctl_write(1'b1, 1'b1, "R10");
    use_op(1'b1, 1); use_op(1'b1, 3);
    reg_write(0, 1 * 4 + 3, 32'h0);
    reg_write(0, 3 * 4 + 3, 32'h0);
    n0 = lg_n;
    pulse_irq(8'h0E);
    tick(3);
    chk("R3", "mask-all blocks", 64'(lg_n), 64'(n0));
    reg_read(1, 0, d); chk("R5", "pending 1,2,3", 64'(d), 64'h0E);
    @(negedge clk) msg_ready = 1'b0;
    ctl_write(1'b0, 1'b1, "R10");
    tick(2);
    chk("R9", "valid waiting", 64'(msg_valid), 64'd1);
    chk("R7", "lowest first", 64'(msg_vec), 64'd1);
    tick(3);
    chk("R9", "vec held", 64'(msg_vec), 64'd1);
    chk("R9", "data held", 64'(msg_data), 64'h101);
    reg_read(1, 0, d); chk("R7", "others still pending", 64'(d), 64'h0C);
    @(negedge clk) msg_ready = 1'b1;
    tick(10);
    chk("R7", "three messages", 64'(lg_n), 64'(n0 + 3));
    chk("R7", "order first", 64'(lg_vec[n0]), 64'd1);
    chk("R7", "order second", 64'(lg_vec[n0 + 1]), 64'd2);
    chk("R7", "order third", 64'(lg_vec[n0 + 2]), 64'd3);
    chk("R7", "third addr", lg_addr[n0 + 2], exp_addr(3));
    reg_read(1, 0, d); chk("R7", "pending empty", 64'(d), 64'd0);
  endtask

  task automatic t_use_count;
    logic [31:0] d;
    int n0;
    reg_write(0, 5 * 4 + 3, 32'h1);
    pulse_irq(8'h20);
    reg_read(1, 0, d); chk("R5", "pending 5 again", 64'(d), 64'h20);
    use_op(1'b0, 5);
    reg_read(1, 0, d); chk("R11", "release clears pending", 64'(d), 64'd0);
    use_op(1'b0, 5);
    use_op(1'b1, 5);
    n0 = lg_n;
    pulse_irq(8'h20);
    tick(2);
    reg_read(1, 0, d); chk("R11", "decrement at zero ignored", 64'(d), 64'h20);
    chk("R11", "no message", 64'(lg_n), 64'(n0));
  endtask

  task automatic t_enable_gate;
    logic [31:0] d;
    int n0;
    ctl_write(1'b0, 1'b0, "R10");
    tick(1);
    chk("R10", "intx_clr stays low", 64'(intx_clr), 64'd0);
    n0 = lg_n;
    pulse_irq(8'h04);
    tick(3);
    chk("R3", "disabled blocks", 64'(lg_n), 64'(n0));
    reg_read(1, 0, d); chk("R3", "pending 2 and 5", 64'(d), 64'h24);
    ctl_write(1'b0, 1'b1, "R10");
    tick(4);
    chk("R7", "enable replays", 64'(lg_n), 64'(n0 + 1));
    chk("R7", "enable replays vec2", 64'(lg_vec[n0]), 64'd2);
    reg_read(1, 0, d); chk("R3", "masked 5 stays", 64'(d), 64'h20);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset;
    t_table;
    t_drop_unused;
    t_immediate;
    t_masked_replay;
    t_function_mask;
    t_use_count;
    t_enable_gate;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule